// File: doc/BRIEF.md
# Packet stream delimiter framer

The framer turns a sequence of variable-length packets into one 32-bit word stream bound for a device. For each packet it emits a delimiter word in front of the payload. The delimiter carries the padded length biased by a fixed offset, a 3-bit pool selector, the count of pad bytes, an interrupt-request bit and a 7-bit CRC. The payload then follows, padded with zero bytes up to a 4-byte boundary.

Packets arrive as a descriptor handshake (length, pool, end-of-batch flags) followed by payload words, four bytes per word with the first byte in the least significant lane. The output is grouped into transfer windows of at most `WINDOW_BYTES` bytes. A packet is never split across two windows. When the next packet would not fit, the current window is closed with a flush strobe that reports its byte count, before that packet's delimiter is sent. A window is also flushed when a batch ends. Admission checks and the bus that carries the windows are outside this block. Packet lengths are at least 1.

Top module: `delim_framer`

## Requirements
- R1: Delimiter bits [13:0] equal the packet length rounded up to a multiple of 4, plus 256, taken modulo 2^14.
- R2: Delimiter bits [16:14] carry the packet's pool ID, and bits [24:20] are zero.
- R3: Delimiter bits [18:17] hold the pad count. It is 0 when the length is a multiple of 4; otherwise it is 4 minus (length mod 4).
- R4: Delimiter bits [31:25] hold a CRC-7 with polynomial x^7+x^3+1 and initial value 0. It is computed over the delimiter with bits [31:25] taken as zero, most significant bit first.
- R5: Each packet appears on the output as its delimiter word followed by ceil(length/4) payload words. Packet byte k sits in bits [8*(k mod 4)+7 : 8*(k mod 4)] of output payload word k/4.
- R6: Output bytes beyond the packet length in the final payload word are zero, whatever the input word holds there.
- R7: If the window is non-empty and adding 4 plus the padded length of the next packet would exceed `WINDOW_BYTES`, a flush strobe reports the bytes emitted since the last flush, before that packet's delimiter. An empty window is never flushed, and a window that ends exactly full is not flushed early.
- R8: Delimiter bit 19 is set exactly when the packet is marked last-of-batch or its successor was rejected.
- R9: After the final payload word of a packet that ends a batch (last-of-batch or successor rejected), a flush strobe reports the window's byte count, and the window restarts empty.
- R10: While a flush strobe is high, neither a descriptor nor a payload word is accepted.
- R11: After reset the block accepts a descriptor and drives no output word, no payload-ready and no flush strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Descriptor valid |
| pkt_ready | output | 1 | Descriptor accepted when high with pkt_valid |
| pkt_len | input | LEN_W | Packet length in bytes (at least 1) |
| pkt_pool | input | POOL_W | Pool/queue selector placed in the delimiter |
| pkt_last | input | 1 | Packet is the last of its batch |
| pkt_next_rej | input | 1 | The following packet was rejected; this packet ends the batch |
| dat_valid | input | 1 | Payload word valid |
| dat_ready | output | 1 | Payload word accepted when high with dat_valid |
| dat_word | input | 32 | Payload bytes, first byte in bits [7:0] |
| out_valid | output | 1 | Output word valid |
| out_word | output | 32 | Delimiter or payload word |
| flush_strb | output | 1 | Window closed this cycle |
| flush_bytes | output | clog2(WINDOW_BYTES+1) | Byte count of the closed window |

## Verification
The bench aims at payload lengths in each residue mod 4, so that pad count, rounded length field and zeroed tail lanes are all exercised. A design that pads from the wrong end would leak input bytes or drop real ones. It runs a batch whose packets fill the window to exactly its limit, which a design with an off-by-one fit test would flush one packet early, and a batch that overflows, which a design ignoring the window would send as one oversized transfer. It also runs a batch cut short by a rejected successor, where a design that only honours the last flag would omit the interrupt bit and the flush. The CRC is checked against a byte-wise reference, so any wrong polynomial, bit order or masking of the CRC field shows up.

// File: rtl/dfr_pkg.sv
package dfr_pkg;

   typedef enum logic [2:0] {
      ST_HDR,
      ST_PRE,
      ST_DELIM,
      ST_DATA,
      ST_END
   } dfr_state_t;

   localparam logic [6:0] CRC7_POLY = 7'h09;

   // Bit-serial CRC-7, MSB first, zero seed.
   function automatic logic [6:0] dfr_crc7(input logic [31:0] w);
      logic [6:0] c;
      logic       fb;
      c = '0;
      for (int i = 31; i >= 0; i--) begin
         fb = c[6] ^ w[i];
         c  = {c[5:0], 1'b0};
         if (fb) c = c ^ CRC7_POLY;
      end
      return c;
   endfunction

endpackage

// File: rtl/dfr_hdr.sv
module dfr_hdr #(
   parameter int LEN_W      = 14,
   parameter int POOL_W     = 3,
   parameter int RSV_OFFSET = 256
) (
   input  logic [LEN_W-1:0]  len,
   input  logic [POOL_W-1:0] pool,
   input  logic              irq,
   output logic [31:0]       delim,
   output logic [LEN_W:0]    padded
);
   import dfr_pkg::*;

   localparam int POOL_LSB = LEN_W;
   localparam int PAD_LSB  = POOL_LSB + POOL_W;
   localparam int IRQ_BIT  = PAD_LSB + 2;
   localparam int CRC_LSB  = 25;

   if (IRQ_BIT >= CRC_LSB) begin : g_bad_layout
      $error("dfr_hdr: fields overlap the CRC field");
   end

   logic [1:0]       pad;
   logic [LEN_W-1:0] len_field;
   logic [31:0]      body;

   always_comb begin
      pad       = 2'(3'd4 - {1'b0, len[1:0]});
      padded    = {1'b0, len} + {{(LEN_W-1){1'b0}}, pad};
      len_field = LEN_W'(32'(padded) + RSV_OFFSET);
      body                        = '0;
      body[LEN_W-1:0]             = len_field;
      body[POOL_LSB +: POOL_W]    = pool;
      body[PAD_LSB +: 2]          = pad;
      body[IRQ_BIT]               = irq;
      delim                       = body;
      delim[31:CRC_LSB]           = dfr_crc7(body);
   end

endmodule

// File: rtl/dfr_window.sv
module dfr_window #(
   parameter int WINDOW_BYTES = 32768,
   parameter int LEN_W        = 14
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              add_word,
   input  logic                              clr,
   input  logic [LEN_W:0]                    next_padded,
   output logic [$clog2(WINDOW_BYTES+1)-1:0] win,
   output logic                              need_flush
);
   localparam int WCNT_W = $clog2(WINDOW_BYTES + 1);
   localparam int BASE_W = (WCNT_W > LEN_W + 1) ? WCNT_W : LEN_W + 1;
   localparam int SUM_W  = BASE_W + 2;

   if (WINDOW_BYTES % 4 != 0 || WINDOW_BYTES < 8) begin : g_bad_window
      $error("dfr_window: window must be a word multiple of at least 8 bytes");
   end

   logic [WCNT_W-1:0] win_q;
   logic [SUM_W-1:0]  sum;

   always_comb begin
      sum        = SUM_W'(win_q) + SUM_W'(next_padded) + SUM_W'(4);
      need_flush = (win_q != '0) && (sum > SUM_W'(WINDOW_BYTES));
      win        = win_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        win_q <= '0;
      else if (clr)      win_q <= '0;
      else if (add_word) win_q <= win_q + WCNT_W'(4);
   end

endmodule

// File: rtl/dfr_mask.sv
module dfr_mask #(
   parameter int WORD_W = 32
) (
   input  logic [WORD_W-1:0]                din,
   input  logic                             last,
   input  logic [$clog2(WORD_W/8)-1:0]      tail,
   output logic [WORD_W-1:0]                dout
);
   localparam int LANES  = WORD_W / 8;
   localparam int TAIL_W = $clog2(LANES);

   if (WORD_W % 8 != 0 || LANES < 2) begin : g_bad_word
      $error("dfr_mask: word must hold at least two bytes");
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic keep;
      always_comb begin
         keep = !last || (tail == '0) || (TAIL_W'(g) < tail);
         dout[8*g +: 8] = keep ? din[8*g +: 8] : 8'h00;
      end
   end

endmodule

// File: rtl/delim_framer.sv
module delim_framer #(
   parameter int WINDOW_BYTES = 32768,
   parameter int LEN_W        = 14,
   parameter int POOL_W       = 3,
   parameter int RSV_OFFSET   = 256
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              pkt_valid,
   output logic                              pkt_ready,
   input  logic [LEN_W-1:0]                  pkt_len,
   input  logic [POOL_W-1:0]                 pkt_pool,
   input  logic                              pkt_last,
   input  logic                              pkt_next_rej,
   input  logic                              dat_valid,
   output logic                              dat_ready,
   input  logic [31:0]                       dat_word,
   output logic                              out_valid,
   output logic [31:0]                       out_word,
   output logic                              flush_strb,
   output logic [$clog2(WINDOW_BYTES+1)-1:0] flush_bytes
);
   import dfr_pkg::*;

   localparam int WCNT_W = $clog2(WINDOW_BYTES + 1);
   localparam int WLEN_W = LEN_W - 1;

   if (LEN_W < 3 || LEN_W > 24) begin : g_bad_len
      $error("delim_framer: LEN_W out of range");
   end

   dfr_state_t        st_q;
   logic [LEN_W-1:0]  len_q;
   logic [POOL_W-1:0] pool_q;
   logic              irq_q;
   logic [WLEN_W-1:0] wleft_q;

   logic [31:0]       delim;
   logic [LEN_W:0]    padded_q;
   logic [LEN_W:0]    in_padded;
   logic [1:0]        in_pad;
   logic [31:0]       masked;
   logic [WCNT_W-1:0] win;
   logic              need_flush;
   logic              pkt_take;
   logic              dat_take;
   logic              last_word;

   dfr_hdr #(
      .LEN_W      (LEN_W),
      .POOL_W     (POOL_W),
      .RSV_OFFSET (RSV_OFFSET)
   ) u_hdr (
      .len    (len_q),
      .pool   (pool_q),
      .irq    (irq_q),
      .delim  (delim),
      .padded (padded_q)
   );

   dfr_window #(
      .WINDOW_BYTES (WINDOW_BYTES),
      .LEN_W        (LEN_W)
   ) u_win (
      .clk         (clk),
      .rst_n       (rst_n),
      .add_word    (out_valid),
      .clr         (flush_strb),
      .next_padded (in_padded),
      .win         (win),
      .need_flush  (need_flush)
   );

   dfr_mask #(
      .WORD_W (32)
   ) u_mask (
      .din  (dat_word),
      .last (last_word),
      .tail (len_q[1:0]),
      .dout (masked)
   );

   always_comb begin
      in_pad     = 2'(3'd4 - {1'b0, pkt_len[1:0]});
      in_padded  = {1'b0, pkt_len} + {{(LEN_W-1){1'b0}}, in_pad};
      pkt_ready  = (st_q == ST_HDR);
      dat_ready  = (st_q == ST_DATA);
      pkt_take   = pkt_ready && pkt_valid;
      dat_take   = dat_ready && dat_valid;
      last_word  = (wleft_q == WLEN_W'(1));
      out_valid  = (st_q == ST_DELIM) || dat_take;
      out_word   = (st_q == ST_DELIM) ? delim : masked;
      flush_strb = (st_q == ST_PRE) || ((st_q == ST_END) && (win != '0));
      flush_bytes = win;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_HDR;
         len_q   <= '0;
         pool_q  <= '0;
         irq_q   <= 1'b0;
         wleft_q <= '0;
      end else begin
         unique case (st_q)
            ST_HDR: begin
               if (pkt_take) begin
                  len_q  <= pkt_len;
                  pool_q <= pkt_pool;
                  irq_q  <= pkt_last || pkt_next_rej;
                  st_q   <= need_flush ? ST_PRE : ST_DELIM;
               end
            end
            ST_PRE: st_q <= ST_DELIM;
            ST_DELIM: begin
               wleft_q <= WLEN_W'(padded_q >> 2);
               st_q    <= ST_DATA;
            end
            ST_DATA: begin
               if (dat_take) begin
                  wleft_q <= wleft_q - WLEN_W'(1);
                  if (last_word) st_q <= irq_q ? ST_END : ST_HDR;
               end
            end
            ST_END: st_q <= ST_HDR;
            default: st_q <= ST_HDR;
         endcase
      end
   end

endmodule

// File: rtl/delim_framer_chk.sv
module delim_framer_chk #(
   parameter int WINDOW_BYTES = 32768,
   parameter int POOL_W       = 3
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic                              pkt_valid,
   input logic                              pkt_ready,
   input logic [POOL_W-1:0]                 pkt_pool,
   input logic                              dat_valid,
   input logic                              dat_ready,
   input logic                              out_valid,
   input logic [31:0]                       out_word,
   input logic                              flush_strb,
   input logic [$clog2(WINDOW_BYTES+1)-1:0] flush_bytes
);
   localparam int RUN_W = $clog2(WINDOW_BYTES + 1) + 2;

   logic [RUN_W-1:0]  run_q;
   logic              hdr_next_q;
   logic [POOL_W-1:0] pool_lat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q      <= '0;
         hdr_next_q <= 1'b0;
         pool_lat_q <= '0;
      end else begin
         if (flush_strb)     run_q <= '0;
         else if (out_valid) run_q <= run_q + RUN_W'(4);
         if (pkt_valid && pkt_ready) begin
            hdr_next_q <= 1'b1;
            pool_lat_q <= pkt_pool;
         end else if (out_valid) begin
            hdr_next_q <= 1'b0;
         end
      end
   end

   assert_flush_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flush_strb |-> (RUN_W'(flush_bytes) == run_q));

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= RUN_W'(WINDOW_BYTES));

   assert_no_empty_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flush_strb |-> (flush_bytes != '0));

   assert_single_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush_strb |=> !flush_strb);

   assert_hold_in_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flush_strb |-> (!pkt_ready && !dat_ready));

   assert_beat_passes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_valid && dat_ready) |-> out_valid);

   assert_delim_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && hdr_next_q) |-> ((out_word[24:20] == 5'd0) &&
                                     (out_word[14 +: POOL_W] == pool_lat_q)));

   assert_reset_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pkt_ready && !out_valid && !flush_strb));

endmodule

bind delim_framer delim_framer_chk #(
   .WINDOW_BYTES (WINDOW_BYTES),
   .POOL_W       (POOL_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pkt_valid   (pkt_valid),
   .pkt_ready   (pkt_ready),
   .pkt_pool    (pkt_pool),
   .dat_valid   (dat_valid),
   .dat_ready   (dat_ready),
   .out_valid   (out_valid),
   .out_word    (out_word),
   .flush_strb  (flush_strb),
   .flush_bytes (flush_bytes)
);

// File: tb/delim_framer_bench.sv
module delim_framer_bench;
   localparam int WIN    = 32768;
   localparam int LEN_W  = 14;
   localparam int POOL_W = 3;
   localparam int WCNT_W = $clog2(WIN + 1);

   logic              clk;
   logic              rst_n;
   logic              pkt_valid;
   logic              pkt_ready;
   logic [LEN_W-1:0]  pkt_len;
   logic [POOL_W-1:0] pkt_pool;
   logic              pkt_last;
   logic              pkt_next_rej;
   logic              dat_valid;
   logic              dat_ready;
   logic [31:0]       dat_word;
   logic              out_valid;
   logic [31:0]       out_word;
   logic              flush_strb;
   logic [WCNT_W-1:0] flush_bytes;

   int checks   = 0;
   int failures = 0;
   int bp_bad   = 0;
   int exp_win  = 0;

   logic [31:0] got_w[$];
   int          got_f[$];
   logic [31:0] exp_w[$];
   int          exp_k[$];   // 0 full data, 1 tail data, 2 delimiter
   int          exp_f[$];
   int          exp_fk[$];  // 7 window overflow, 9 batch end

   delim_framer #(
      .WINDOW_BYTES (WIN),
      .LEN_W        (LEN_W),
      .POOL_W       (POOL_W),
      .RSV_OFFSET   (256)
   ) u_delim_framer (
      .clk          (clk),
      .rst_n        (rst_n),
      .pkt_valid    (pkt_valid),
      .pkt_ready    (pkt_ready),
      .pkt_len      (pkt_len),
      .pkt_pool     (pkt_pool),
      .pkt_last     (pkt_last),
      .pkt_next_rej (pkt_next_rej),
      .dat_valid    (dat_valid),
      .dat_ready    (dat_ready),
      .dat_word     (dat_word),
      .out_valid    (out_valid),
      .out_word     (out_word),
      .flush_strb   (flush_strb),
      .flush_bytes  (flush_bytes)
   );

   initial clk = 1'b0;
   always #2 clk = ~clk;

   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid) got_w.push_back(out_word);
         if (flush_strb) begin
            got_f.push_back(int'(flush_bytes));
            if (pkt_ready || dat_ready) bp_bad++;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   // Byte-wise reference CRC, register held in the top 7 bits of a byte.
   function automatic logic [6:0] ref_crc(input logic [31:0] d);
      logic [7:0] c = 8'h00;
      for (int j = 3; j >= 0; j--) begin
         c = c ^ d[8*j +: 8];
         for (int b = 0; b < 8; b++) c = c[7] ? ((c << 1) ^ 8'h12) : (c << 1);
      end
      return c[7:1];
   endfunction

   function automatic logic [31:0] ref_delim(input int len, input int pool, input bit irq);
      int pad = (4 - (len % 4)) % 4;
      logic [31:0] d = '0;
      d[13:0]  = 14'((len + pad + 256) % 16384);
      d[16:14] = 3'(pool);
      d[18:17] = 2'(pad);
      d[19]    = irq;
      d[31:25] = ref_crc(d);
      return d;
   endfunction

   function automatic logic [7:0] pat(input int seed, input int k);
      return 8'(seed * 13 + k * 7 + 1);
   endfunction

   task automatic send_pkt(input int len, input int pool, input bit last,
                           input bit rej, input int seed);
      int pad  = (4 - (len % 4)) % 4;
      int plen = len + pad;
      if (exp_win != 0 && exp_win + 4 + plen > WIN) begin
         exp_f.push_back(exp_win); exp_fk.push_back(7); exp_win = 0;
      end
      exp_w.push_back(ref_delim(len, pool, last | rej)); exp_k.push_back(2);
      for (int w = 0; w < plen / 4; w++) begin
         logic [31:0] e;
         for (int b = 0; b < 4; b++) e[8*b +: 8] = (4*w + b < len) ? pat(seed, 4*w + b) : 8'h00;
         exp_w.push_back(e); exp_k.push_back((4*w + 4 > len) ? 1 : 0);
      end
      exp_win += 4 + plen;
      if (last | rej) begin
         exp_f.push_back(exp_win); exp_fk.push_back(9); exp_win = 0;
      end
      pkt_valid = 1'b1; pkt_len = LEN_W'(len); pkt_pool = POOL_W'(pool);
      pkt_last = last; pkt_next_rej = rej;
      do @(negedge clk); while (!pkt_ready);
      @(posedge clk); #1;
      pkt_valid = 1'b0;
      for (int w = 0; w < plen / 4; w++) begin
         dat_valid = 1'b1;
         for (int b = 0; b < 4; b++) dat_word[8*b +: 8] = (4*w + b < len) ? pat(seed, 4*w + b) : 8'hEE;
         do @(negedge clk); while (!dat_ready);
         @(posedge clk); #1;
      end
      dat_valid = 1'b0;
   endtask

   task automatic check_stream(input string name);
      int n;
      repeat (4) @(posedge clk);
      #1;
      chk(got_w.size() == exp_w.size(), "R5", {name, " word count"}, got_w.size(), exp_w.size());
      n = (got_w.size() < exp_w.size()) ? got_w.size() : exp_w.size();
      for (int i = 0; i < n; i++) begin
         logic [31:0] g = got_w[i];
         logic [31:0] e = exp_w[i];
         if (exp_k[i] == 2) begin
            chk(g[13:0] == e[13:0], "R1", {name, " length field"}, g[13:0], e[13:0]);
            chk({g[24:20], g[16:14]} == {e[24:20], e[16:14]}, "R2", {name, " pool/zero field"}, g[24:14], e[24:14]);
            chk(g[18:17] == e[18:17], "R3", {name, " pad field"}, g[18:17], e[18:17]);
            chk(g[19] == e[19], "R8", {name, " irq bit"}, g[19], e[19]);
            chk(g[31:25] == e[31:25], "R4", {name, " crc field"}, g[31:25], e[31:25]);
         end else if (exp_k[i] == 1) begin
            chk(g == e, "R6", {name, " tail word"}, g, e);
         end else begin
            chk(g == e, "R5", {name, " payload word"}, g, e);
         end
      end
      chk(got_f.size() == exp_f.size(), "R7", {name, " flush count"}, got_f.size(), exp_f.size());
      n = (got_f.size() < exp_f.size()) ? got_f.size() : exp_f.size();
      for (int i = 0; i < n; i++) begin
         if (exp_fk[i] == 7) chk(got_f[i] == exp_f[i], "R7", {name, " window flush bytes"}, got_f[i], exp_f[i]);
         else                chk(got_f[i] == exp_f[i], "R9", {name, " batch flush bytes"}, got_f[i], exp_f[i]);
      end
      got_w.delete(); exp_w.delete(); exp_k.delete();
      got_f.delete(); exp_f.delete(); exp_fk.delete();
   endtask

   task automatic t_reset();
      rst_n = 1'b0; pkt_valid = 1'b0; dat_valid = 1'b0; dat_word = '0;
      pkt_len = '0; pkt_pool = '0; pkt_last = 1'b0; pkt_next_rej = 1'b0;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(pkt_ready == 1'b1, "R11", "pkt_ready after reset", pkt_ready, 1);
      chk(out_valid == 1'b0, "R11", "out_valid after reset", out_valid, 0);
      chk(dat_ready == 1'b0, "R11", "dat_ready after reset", dat_ready, 0);
      chk(flush_strb == 1'b0, "R11", "flush after reset", flush_strb, 0);
      @(posedge clk); #1;
   endtask

   // R1 R3 R6: every length residue, each packet its own batch.
   task automatic t_sizes();
      send_pkt(1, 0, 1'b1, 1'b0, 3);
      send_pkt(2, 1, 1'b1, 1'b0, 5);
      send_pkt(3, 2, 1'b1, 1'b0, 8);
      send_pkt(4, 3, 1'b1, 1'b0, 11);
      send_pkt(5, 7, 1'b1, 1'b0, 17);
      check_stream("sizes");
   endtask

   // R8: irq only on the last packet; one flush at batch end.
   task automatic t_batch();
      send_pkt(10, 4, 1'b0, 1'b0, 21);
      send_pkt(7, 5, 1'b0, 1'b0, 22);
      send_pkt(33, 6, 1'b0, 1'b0, 23);
      send_pkt(2, 2, 1'b1, 1'b0, 24);
      check_stream("batch");
   endtask

   // R8 R9: rejected successor ends the batch early.
   task automatic t_reject();
      send_pkt(9, 1, 1'b0, 1'b0, 31);
      send_pkt(14, 3, 1'b0, 1'b1, 32);
      send_pkt(6, 0, 1'b1, 1'b0, 33);
      check_stream("reject");
   endtask

   // R7: third packet does not fit, window closed first.
   task automatic t_window_split();
      send_pkt(12000, 1, 1'b0, 1'b0, 41);
      send_pkt(12000, 2, 1'b0, 1'b0, 42);
      send_pkt(12000, 3, 1'b1, 1'b0, 43);
      check_stream("window_split");
   endtask

   // R7: four packets fill the window exactly; the fifth forces the flush.
   task automatic t_window_exact();
      for (int p = 0; p < 5; p++) send_pkt(8187 + (p % 2), p, p == 4, 1'b0, 50 + p);
      check_stream("window_exact");
   endtask

   initial begin
      t_reset();
      t_sizes();
      t_batch();
      t_reject();
      t_window_split();
      t_window_exact();
      chk(bp_bad == 0, "R10", "input accepted during flush", bp_bad, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule